// File: doc/BRIEF.md
# Adjacent-Line Pair Prefetcher

This block sits next to a second-level cache and watches its request stream. Memory is viewed as 128-byte blocks aligned on 128-byte boundaries, and each block holds two 64-byte lines. When a qualifying request misses on one line of a block, the block queues a prefetch for the other line of that pair, so the whole 128-byte block ends up in the cache.

A request qualifies only when all of these hold:
- its memory type is write-back;
- its source is one of the allowed requesters;
- it is a miss;
- the cache does not already report the companion line as present;
- the block was not among the last four blocks prefetched.

Qualified prefetches wait in a two-entry queue and leave through a valid/ready handshake. A trigger that arrives while the queue is full is dropped.

Top module: `pair_prefetcher`

## Requirements
- R1: The prefetch address is the trigger address with bit 6 inverted and bits 5:0 forced to zero. All bits from 7 upward are unchanged, so the prefetch never leaves the trigger's 4 KB page.
- R2: Only memory type code 3'b110 (write-back) can trigger a prefetch. Every other `in_memtype` code causes no prefetch.
- R3: Source codes 0 (demand), 1 (software prefetch), 2 (first-level prefetcher) and 3 (second-level miss-driven prefetch logic) can trigger. Codes 4 to 7 cause no prefetch.
- R4: A request with `in_miss` low (a hit) causes no prefetch.
- R5: A request with `in_buddy_hit` high (companion line already cached) causes no prefetch.
- R6: The addresses of the last four prefetched blocks (bits 7 and up) are remembered. A trigger to a remembered block causes no prefetch. A new block replaces the oldest remembered one.
- R7: At most two prefetches wait at a time. A trigger that arrives while two are waiting is dropped and is not remembered by the R6 filter.
- R8: While `pf_valid` is high and `pf_ready` is low, `pf_valid` stays high and `pf_addr` stays unchanged.
- R9: A trigger sampled at a clock edge is visible on `pf_valid`/`pf_addr` from that edge on when the queue is empty. Prefetches leave in the order of their triggers.
- R10: After reset, `pf_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An observed cache request is present |
| in_addr | input | ADDR_W | Byte address of the request |
| in_memtype | input | 3 | Memory type code; 3'b110 means write-back |
| in_src | input | 3 | Request source code (0..3 may trigger) |
| in_miss | input | 1 | The request missed the second-level cache |
| in_buddy_hit | input | 1 | The companion line is already present |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_addr | output | ADDR_W | Line address of the offered prefetch |
| pf_ready | input | 1 | The consumer accepts the offered prefetch |

## Verification
A corrupted history filter shows up at the ports as a missing prefetch, or as a repeated one. This appears on the very next trigger to the affected block, one edge after it is sampled. A wrong queue count or pointer shows within a few cycles, in one of these ways:
- an output that arrives out of order or is duplicated;
- a prefetch lost while the queue should have had room;
- a prefetch accepted while two were already waiting.

The scoreboard catches each of these when the next entry is compared or when the run drains. A wrong address path shows on the first output as a mismatch in bit 6, in the low bits or in the page bits.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int unsigned LINE_LSB   = 6;
  localparam logic [2:0]  MT_WB      = 3'b110;
  localparam logic [2:0]  SRC_LAST   = 3'd3;
  localparam int unsigned HIST_DEPTH = 4;
  localparam int unsigned Q_DEPTH    = 2;
endpackage

// File: rtl/pfx_qualify.sv
module pfx_qualify
  import pfx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2:0]        req_memtype,
  input  logic [2:0]        req_src,
  input  logic              req_miss,
  input  logic              req_buddy_hit,
  output logic              want,
  output logic [ADDR_W-1:0] tgt_addr
);
  logic [LINE_LSB-1:0] unused_low;

  assign unused_low = req_addr[LINE_LSB-1:0];

  always_comb begin
    want = req_valid && req_miss && !req_buddy_hit &&
           (req_memtype == MT_WB) && (req_src <= SRC_LAST);
    tgt_addr = {req_addr[ADDR_W-1:LINE_LSB+1], ~req_addr[LINE_LSB], {LINE_LSB{1'b0}}};
  end
endmodule

// File: rtl/pfx_filter.sv
module pfx_filter #(
  parameter int unsigned TAG_W   = 25,
  parameter int unsigned ENTRIES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] look_tag,
  output logic             hit,
  input  logic             rec_en,
  input  logic [TAG_W-1:0] rec_tag
);
  localparam int unsigned PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [TAG_W-1:0] tag_q [ENTRIES];
  logic [ENTRIES-1:0] vld_q, vld_d, match;
  logic [PTR_W-1:0] ptr_q, ptr_d;

  genvar gi;
  generate
    for (gi = 0; gi < ENTRIES; gi++) begin : g_cmp
      assign match[gi] = vld_q[gi] && (tag_q[gi] == look_tag);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tag_q[gi] <= '0;
        else if (rec_en && (ptr_q == PTR_W'(gi))) tag_q[gi] <= rec_tag;
      end
    end
  endgenerate

  assign hit = |match;

  always_comb begin
    vld_d = vld_q;
    ptr_d = ptr_q;
    if (rec_en) begin
      vld_d[ptr_q] = 1'b1;
      ptr_d = (ptr_q == PTR_W'(ENTRIES-1)) ? '0 : ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
      ptr_q <= '0;
    end else begin
      vld_q <= vld_d;
      ptr_q <= ptr_d;
    end
  end
endmodule

// File: rtl/pfx_fifo.sv
module pfx_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  output logic                       full,
  input  logic                       pop,
  output logic                       valid,
  output logic [W-1:0]               dout,
  output logic [$clog2(DEPTH+1)-1:0] count
);
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic [W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, wr_d, rd_q, rd_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign valid   = (cnt_q != '0);
  assign dout    = mem_q[rd_q];
  assign count   = cnt_q;
  assign do_push = push && !full;
  assign do_pop  = pop && valid;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_q[gi] <= '0;
        else if (do_push && (wr_q == PTR_W'(gi))) mem_q[gi] <= din;
      end
    end
  endgenerate

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    cnt_d = cnt_q;
    if (do_push) wr_d = (wr_q == PTR_W'(DEPTH-1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == PTR_W'(DEPTH-1)) ? '0 : rd_q + 1'b1;
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pair_prefetcher.sv
module pair_prefetcher
  import pfx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [2:0]        in_memtype,
  input  logic [2:0]        in_src,
  input  logic              in_miss,
  input  logic              in_buddy_hit,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  input  logic              pf_ready
);
  localparam int unsigned TAG_W = ADDR_W - (LINE_LSB + 1);
  localparam int unsigned CNT_W = $clog2(Q_DEPTH+1);

  logic              want, filt_hit, q_full, accept;
  logic [ADDR_W-1:0] tgt_addr;
  logic [TAG_W-1:0]  blk_tag;
  logic [CNT_W-1:0]  q_count;

  assign blk_tag = in_addr[ADDR_W-1:LINE_LSB+1];

  pfx_qualify #(.ADDR_W(ADDR_W)) u_qual (
    .req_valid    (in_valid),
    .req_addr     (in_addr),
    .req_memtype  (in_memtype),
    .req_src      (in_src),
    .req_miss     (in_miss),
    .req_buddy_hit(in_buddy_hit),
    .want         (want),
    .tgt_addr     (tgt_addr)
  );

  assign accept = want && !filt_hit && !q_full;

  pfx_filter #(.TAG_W(TAG_W), .ENTRIES(HIST_DEPTH)) u_filt (
    .clk     (clk),
    .rst_n   (rst_n),
    .look_tag(blk_tag),
    .hit     (filt_hit),
    .rec_en  (accept),
    .rec_tag (blk_tag)
  );

  pfx_fifo #(.W(ADDR_W), .DEPTH(Q_DEPTH)) u_q (
    .clk  (clk),
    .rst_n(rst_n),
    .push (accept),
    .din  (tgt_addr),
    .full (q_full),
    .pop  (pf_ready),
    .valid(pf_valid),
    .dout (pf_addr),
    .count(q_count)
  );
endmodule

// File: rtl/pfx_checker.sv
module pfx_checker
  import pfx_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        in_memtype,
  input logic [2:0]        in_src,
  input logic              in_miss,
  input logic              pf_valid,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              pf_ready,
  input logic [CNT_W-1:0]  q_count
);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pf_valid && !pf_ready) |=> (pf_valid && $stable(pf_addr)));

  assert_line_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pf_valid |-> (pf_addr[LINE_LSB-1:0] == '0));

  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(Q_DEPTH));

  assert_wb_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_memtype != MT_WB) && !(pf_valid && pf_ready))
      |=> (q_count == $past(q_count)));

  assert_src_gate_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (in_src > SRC_LAST) && !(pf_valid && pf_ready))
      |=> (q_count == $past(q_count)));

  assert_hit_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_miss && !(pf_valid && pf_ready))
      |=> (q_count == $past(q_count)));
endmodule

bind pair_prefetcher pfx_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_memtype(in_memtype),
  .in_src    (in_src),
  .in_miss   (in_miss),
  .pf_valid  (pf_valid),
  .pf_addr   (pf_addr),
  .pf_ready  (pf_ready),
  .q_count   (q_count)
);

// File: tb/sim_pair_prefetcher.sv
`timescale 1ns/1ps
module sim_pair_prefetcher;
  localparam int unsigned AW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid, in_miss, in_buddy_hit, pf_ready, pf_valid;
  logic [AW-1:0] in_addr, pf_addr;
  logic [2:0]    in_memtype, in_src;

  int checks = 0;
  int errors = 0;
  logic [AW-1:0] exp_q[$];
  string         tag_q[$];

  always #4 clk = ~clk;

  pair_prefetcher #(.ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_addr(in_addr),
    .in_memtype(in_memtype), .in_src(in_src), .in_miss(in_miss),
    .in_buddy_hit(in_buddy_hit), .pf_valid(pf_valid), .pf_addr(pf_addr),
    .pf_ready(pf_ready)
  );

  function automatic logic [AW-1:0] buddy(input logic [AW-1:0] a);
    return {a[AW-1:7], ~a[6], 6'd0};
  endfunction

  // Monitor: pops scoreboard on each accepted output.
  always @(negedge clk) begin
    if (rst_n && pf_valid && pf_ready) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected output: actual %h expected none (R2/R3/R4/R5/R6)", pf_addr);
      end else begin
        logic [AW-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (pf_addr !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, pf_addr, e);
        end
      end
    end
  end

  task automatic trig(input logic [AW-1:0] a, input logic [2:0] mt,
                      input logic [2:0] src, input logic miss, input logic bh,
                      input logic expect_pf, input string t);
    @(posedge clk); #1;
    in_valid = 1'b1; in_addr = a; in_memtype = mt; in_src = src;
    in_miss = miss; in_buddy_hit = bh;
    if (expect_pf) begin
      exp_q.push_back(buddy(a));
      tag_q.push_back(t);
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
  endtask

  task automatic expect_idle(input string t);
    @(negedge clk);
    checks++;
    if (pf_valid !== 1'b0) begin
      errors++;
      $display("FAIL %s: actual pf_valid=%b expected 0", t, pf_valid);
    end
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 20000) begin
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_addr = '0; in_memtype = 3'b110;
    in_src = '0; in_miss = 1'b0; in_buddy_hit = 1'b0; pf_ready = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R10 reset state
    expect_idle("R10");

    // R1 companion: upper line -> lower and lower -> upper, page edge
    trig(32'h0000_0FC4, 3'b110, 3'd0, 1'b1, 1'b0, 1'b1, "R1");
    trig(32'h1234_5E80, 3'b110, 3'd0, 1'b1, 1'b0, 1'b1, "R1");

    // R9 latency: trigger sampled at an edge is visible after it
    @(posedge clk); #1;
    in_valid = 1'b1; in_addr = 32'h0000_2000; in_memtype = 3'b110;
    in_src = 3'd0; in_miss = 1'b1; in_buddy_hit = 1'b0;
    exp_q.push_back(32'h0000_2040); tag_q.push_back("R9");
    @(posedge clk); #1;
    in_valid = 1'b0;
    checks++;
    if (pf_valid !== 1'b1) begin
      errors++;
      $display("FAIL R9: actual pf_valid=%b expected 1", pf_valid);
    end

    // R3 allowed sources 1..3
    trig(32'h0001_0000, 3'b110, 3'd1, 1'b1, 1'b0, 1'b1, "R3");
    trig(32'h0002_0040, 3'b110, 3'd2, 1'b1, 1'b0, 1'b1, "R3");
    trig(32'h0003_0000, 3'b110, 3'd3, 1'b1, 1'b0, 1'b1, "R3");

    // R3 blocked sources
    trig(32'h0004_0000, 3'b110, 3'd4, 1'b1, 1'b0, 1'b0, "R3");
    expect_idle("R3");
    trig(32'h0004_0080, 3'b110, 3'd7, 1'b1, 1'b0, 1'b0, "R3");
    expect_idle("R3");

    // R2 other memory types
    trig(32'h0005_0000, 3'b000, 3'd0, 1'b1, 1'b0, 1'b0, "R2");
    expect_idle("R2");
    trig(32'h0005_0080, 3'b100, 3'd0, 1'b1, 1'b0, 1'b0, "R2");
    expect_idle("R2");

    // R4 hit, R5 companion present
    trig(32'h0006_0000, 3'b110, 3'd0, 1'b0, 1'b0, 1'b0, "R4");
    expect_idle("R4");
    trig(32'h0006_0080, 3'b110, 3'd0, 1'b1, 1'b1, 1'b0, "R5");
    expect_idle("R5");
    // the block of R5 was not remembered: now it prefetches
    trig(32'h0006_0080, 3'b110, 3'd0, 1'b1, 1'b0, 1'b1, "R5");

    // R6 filter: repeat of the same block (other line) is suppressed
    trig(32'h0007_0000, 3'b110, 3'd0, 1'b1, 1'b0, 1'b1, "R6");
    trig(32'h0007_0040, 3'b110, 3'd0, 1'b1, 1'b0, 1'b0, "R6");
    expect_idle("R6");
    // four new blocks push the oldest out
    trig(32'h0008_0000, 3'b110, 3'd0, 1'b1, 1'b0, 1'b1, "R6");
    trig(32'h0008_0080, 3'b110, 3'd0, 1'b1, 1'b0, 1'b1, "R6");
    trig(32'h0008_0100, 3'b110, 3'd0, 1'b1, 1'b0, 1'b1, "R6");
    trig(32'h0007_0040, 3'b110, 3'd0, 1'b1, 1'b0, 1'b0, "R6");
    expect_idle("R6");
    trig(32'h0008_0180, 3'b110, 3'd0, 1'b1, 1'b0, 1'b1, "R6");
    trig(32'h0007_0040, 3'b110, 3'd0, 1'b1, 1'b0, 1'b1, "R6");

    // R7 queue full drops, R8 hold, R9 order
    repeat (3) @(posedge clk);
    #1 pf_ready = 1'b0;
    trig(32'h0009_0000, 3'b110, 3'd0, 1'b1, 1'b0, 1'b1, "R9");
    trig(32'h0009_0080, 3'b110, 3'd0, 1'b1, 1'b0, 1'b1, "R9");
    trig(32'h0009_0100, 3'b110, 3'd0, 1'b1, 1'b0, 1'b0, "R7");
    repeat (4) begin
      @(negedge clk);
      checks++;
      if (pf_valid !== 1'b1 || pf_addr !== 32'h0009_0040) begin
        errors++;
        $display("FAIL R8: actual %b/%h expected 1/%h", pf_valid, pf_addr, 32'h0009_0040);
      end
    end
    @(posedge clk); #1 pf_ready = 1'b1;
    repeat (4) @(posedge clk);
    // R7 dropped block was not remembered
    trig(32'h0009_0100, 3'b110, 3'd0, 1'b1, 1'b0, 1'b1, "R7");
    repeat (4) @(posedge clk);

    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R9: actual %0d outputs missing expected 0", exp_q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule